// File: doc/BRIEF.md
# ECC Read-Return and Scrub Scheduler

This block sits on the read-return path of a memory controller that keeps an error-correcting code beside each stored word. For every returned beat it receives both the raw word and the decoder's corrected word, together with a two-bit decoder status. It forwards one response per beat, in order, to the requesting bus port. It sends an error record to a logging register interface. For a single-bit error, it may also schedule a hidden read-modify-write that writes the corrected word back to the failing address.

Only one write-back may be pending or in flight. A correctable error that arrives while one is active is still corrected and logged, but it is not scrubbed. An uncorrectable word is not blocked. It is passed through unchanged with a slave-error response. The ECC enable and the scrub enable are sampled only while the controller's active-low soft reset is held low, and they govern operation once soft reset is released. Byte-masked writes pass through unchanged, because the code covers each byte on its own and no merge is ever needed.

Top module: `ecc_rdret_scrub`

## Requirements
- R1: With ECC on and decoder status 2'b00 (clean), a beat sampled at a rising edge gives `rsp_vld` high after that same edge, with the raw word and response 2'b00 (OKAY). It produces no log record. There is exactly one response per beat, in beat order, and no response in a cycle that follows no beat.
- R2: With ECC on and status 2'b01 (corrected), the response carries the corrected word with OKAY. In the same cycle a log record appears with `log_uncorr`=0 and the beat's address, and the correctable count has gone up by one.
- R3: With ECC on and status 2'b10 or 2'b11 (uncorrectable), the response carries the raw word with 2'b10 (SLVERR). A log record appears with `log_uncorr`=1 and the uncorrectable count has gone up by one. No scrub is requested.
- R4: With ECC on and scrub on, a corrected beat that finds no scrub pending or busy raises `scr_req_vld` after the same edge, carrying the beat address and the corrected word. The request holds steady until it is accepted with `scr_req_rdy`.
- R5: On acceptance, `scr_busy` rises and `scr_req_vld` falls. `scr_busy` falls after a `scr_done` pulse. A corrected beat that arrives while a request is pending or busy raises no new request and does not change the pending address, yet it is still corrected and logged.
- R6: With scrub disabled (`cfg_scrub_dis`=1 captured), corrected beats never raise `scr_req_vld`.
- R7: Each error count is 8 bits wide and saturates at 255. The counts are cleared only by the hard reset `rst_n`.
- R8: With ECC off (any captured mode other than 3'b100), the decoder status is ignored. Every beat returns the raw word with OKAY, no log record is produced, no scrub is requested, and the counts do not change.
- R9: Mode 3'b100 enables ECC. `cfg_ecc_mode` and `cfg_scrub_dis` are captured only while `soft_rst_n`=0. Changes made while `soft_rst_n`=1 have no effect.
- R10: While `soft_rst_n`=0, beats give no response and no log record, and any pending or busy scrub is cleared.
- R11: Write requests pass combinationally to the memory side unchanged, byte strobes included. They never raise a scrub request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Hard reset, active low |
| soft_rst_n | input | 1 | Controller soft reset, active low; configuration capture window |
| cfg_ecc_mode | input | 3 | ECC mode; 3'b100 enables |
| cfg_scrub_dis | input | 1 | 1 disables scrub write-backs |
| rd_vld | input | 1 | Read beat valid |
| rd_addr | input | AW | Read beat address |
| rd_raw | input | DW | Word as read from memory |
| rd_fix | input | DW | Word after decoder correction |
| rd_stat | input | 2 | Decoder status: 00 clean, 01 corrected, 1x uncorrectable |
| rsp_vld | output | 1 | Response valid |
| rsp_data | output | DW | Response data |
| rsp_resp | output | 2 | Response code, 00 OKAY, 10 SLVERR |
| log_vld | output | 1 | One-cycle log record valid |
| log_uncorr | output | 1 | Record type: 1 uncorrectable, 0 correctable |
| log_addr | output | AW | Failing address |
| log_cnt_ce | output | CNT_W | Saturating correctable count |
| log_cnt_ue | output | CNT_W | Saturating uncorrectable count |
| scr_req_vld | output | 1 | Scrub request valid |
| scr_req_rdy | input | 1 | Scrub request accepted by scheduler |
| scr_addr | output | AW | Scrub address |
| scr_data | output | DW | Corrected word to write back |
| scr_busy | output | 1 | Accepted scrub in flight |
| scr_done | input | 1 | Scheduler pulse: scrub write finished |
| wr_vld | input | 1 | Write request valid |
| wr_addr | input | AW | Write address |
| wr_data | input | DW | Write data |
| wr_strb | input | DW/8 | Write byte strobes |
| mem_wr_vld | output | 1 | Write valid to memory side |
| mem_wr_addr | output | AW | Write address to memory side |
| mem_wr_data | output | DW | Write data to memory side |
| mem_wr_strb | output | DW/8 | Byte strobes to memory side |

## Verification
The response, the log record, the counts and a new scrub request each have one register stage, so all of them are due exactly one edge after the beat is sampled. Accordingly, the bench drives each beat at a falling edge and reads every result at the next falling edge. The scrub state moves on the edge that samples `scr_req_rdy` or `scr_done`, and it is checked at the falling edge that follows. The write path has no register, so it is checked one nanosecond after the stimulus, within the same cycle. A counter model in the bench predicts the saturating counts, and a sweep of all four status codes over several addresses predicts data and response arithmetically.

// File: rtl/ecc_rdret_pkg.sv
package ecc_rdret_pkg;

   localparam logic [2:0] MODE_ECC_ON = 3'b100;
   localparam logic [1:0] RESP_OKAY   = 2'b00;
   localparam logic [1:0] RESP_SLVERR = 2'b10;

   typedef enum logic [1:0] {
      BEAT_CLEAN  = 2'd0,
      BEAT_FIXED  = 2'd1,
      BEAT_UNCORR = 2'd2
   } beat_kind_e;

   typedef enum logic [1:0] {
      SCR_IDLE = 2'd0,
      SCR_REQ  = 2'd1,
      SCR_BUSY = 2'd2
   } scr_state_e;

   function automatic beat_kind_e classify(input logic [1:0] stat);
      if (stat[1])      return BEAT_UNCORR;
      else if (stat[0]) return BEAT_FIXED;
      else              return BEAT_CLEAN;
   endfunction

endpackage

// File: rtl/ecc_cfg_gate.sv
module ecc_cfg_gate
   import ecc_rdret_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       soft_rst_n,
   input  logic [2:0] mode,
   input  logic       scrub_dis,
   output logic       ecc_on,
   output logic       scrub_on
);
   logic ecc_q;
   logic scrub_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ecc_q   <= 1'b0;
         scrub_q <= 1'b0;
      end else if (!soft_rst_n) begin
         ecc_q   <= (mode == MODE_ECC_ON);
         scrub_q <= !scrub_dis;
      end
   end

   assign ecc_on   = ecc_q & soft_rst_n;
   assign scrub_on = scrub_q & ecc_q & soft_rst_n;
endmodule

// File: rtl/ecc_rsp_path.sv
module ecc_rsp_path
   import ecc_rdret_pkg::*;
#(
   parameter int DW = 32
)(
   input  logic          clk,
   input  logic          rst_n,
   input  logic          beat_ev,
   input  logic          ecc_on,
   input  beat_kind_e    kind,
   input  logic [DW-1:0] raw,
   input  logic [DW-1:0] fix,
   output logic          rsp_vld,
   output logic [DW-1:0] rsp_data,
   output logic [1:0]    rsp_resp
);
   logic [DW-1:0] data_d;
   logic [1:0]    resp_d;

   always_comb begin
      data_d = raw;
      resp_d = RESP_OKAY;
      if (ecc_on) begin
         if (kind == BEAT_FIXED)  data_d = fix;
         if (kind == BEAT_UNCORR) resp_d = RESP_SLVERR;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_vld  <= 1'b0;
         rsp_resp <= RESP_OKAY;
      end else begin
         rsp_vld <= beat_ev;
         if (beat_ev) rsp_resp <= resp_d;
      end
   end

   always_ff @(posedge clk) begin
      if (beat_ev) rsp_data <= data_d;
   end
endmodule

// File: rtl/ecc_err_log.sv
module ecc_err_log
   import ecc_rdret_pkg::*;
#(
   parameter int AW    = 16,
   parameter int CNT_W = 8
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             beat_ev,
   input  logic             ecc_on,
   input  beat_kind_e       kind,
   input  logic [AW-1:0]    addr,
   output logic             log_vld,
   output logic             log_uncorr,
   output logic [AW-1:0]    log_addr,
   output logic [CNT_W-1:0] cnt_ce,
   output logic [CNT_W-1:0] cnt_ue
);
   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
   localparam int N_TYPES = 2;

   logic             err_ev;
   logic [CNT_W-1:0] cnt_q [N_TYPES];

   assign err_ev = beat_ev & ecc_on & (kind != BEAT_CLEAN);

   for (genvar t = 0; t < N_TYPES; t++) begin : g_cnt
      localparam beat_kind_e MATCH = (t == 0) ? BEAT_FIXED : BEAT_UNCORR;
      logic hit;
      assign hit = err_ev & (kind == MATCH);
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                        cnt_q[t] <= '0;
         else if (hit && cnt_q[t] != CNT_MAX) cnt_q[t] <= cnt_q[t] + 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         log_vld    <= 1'b0;
         log_uncorr <= 1'b0;
      end else begin
         log_vld <= err_ev;
         if (err_ev) log_uncorr <= (kind == BEAT_UNCORR);
      end
   end

   always_ff @(posedge clk) begin
      if (err_ev) log_addr <= addr;
   end

   assign cnt_ce = cnt_q[0];
   assign cnt_ue = cnt_q[1];
endmodule

// File: rtl/ecc_scrub_ctl.sv
module ecc_scrub_ctl
   import ecc_rdret_pkg::*;
#(
   parameter int AW = 16,
   parameter int DW = 32
)(
   input  logic          clk,
   input  logic          rst_n,
   input  logic          soft_rst_n,
   input  logic          trig,
   input  logic [AW-1:0] addr,
   input  logic [DW-1:0] fix,
   input  logic          req_rdy,
   input  logic          done,
   output logic          req_vld,
   output logic [AW-1:0] req_addr,
   output logic [DW-1:0] req_data,
   output logic          busy
);
   scr_state_e st_q;
   logic       take;

   assign take = soft_rst_n & trig & (st_q == SCR_IDLE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q <= SCR_IDLE;
      end else if (!soft_rst_n) begin
         st_q <= SCR_IDLE;
      end else begin
         unique case (st_q)
            SCR_IDLE: if (take)    st_q <= SCR_REQ;
            SCR_REQ:  if (req_rdy) st_q <= SCR_BUSY;
            SCR_BUSY: if (done)    st_q <= SCR_IDLE;
            default:               st_q <= SCR_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (take) begin
         req_addr <= addr;
         req_data <= fix;
      end
   end

   assign req_vld = (st_q == SCR_REQ);
   assign busy    = (st_q == SCR_BUSY);
endmodule

// File: rtl/ecc_rdret_scrub.sv
module ecc_rdret_scrub
   import ecc_rdret_pkg::*;
#(
   parameter int AW    = 16,
   parameter int DW    = 32,
   parameter int CNT_W = 8
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             soft_rst_n,
   input  logic [2:0]       cfg_ecc_mode,
   input  logic             cfg_scrub_dis,
   input  logic             rd_vld,
   input  logic [AW-1:0]    rd_addr,
   input  logic [DW-1:0]    rd_raw,
   input  logic [DW-1:0]    rd_fix,
   input  logic [1:0]       rd_stat,
   output logic             rsp_vld,
   output logic [DW-1:0]    rsp_data,
   output logic [1:0]       rsp_resp,
   output logic             log_vld,
   output logic             log_uncorr,
   output logic [AW-1:0]    log_addr,
   output logic [CNT_W-1:0] log_cnt_ce,
   output logic [CNT_W-1:0] log_cnt_ue,
   output logic             scr_req_vld,
   input  logic             scr_req_rdy,
   output logic [AW-1:0]    scr_addr,
   output logic [DW-1:0]    scr_data,
   output logic             scr_busy,
   input  logic             scr_done,
   input  logic             wr_vld,
   input  logic [AW-1:0]    wr_addr,
   input  logic [DW-1:0]    wr_data,
   input  logic [DW/8-1:0]  wr_strb,
   output logic             mem_wr_vld,
   output logic [AW-1:0]    mem_wr_addr,
   output logic [DW-1:0]    mem_wr_data,
   output logic [DW/8-1:0]  mem_wr_strb
);
   if (DW % 8 != 0 || DW < 8) begin : g_bad_dw
      $error("ecc_rdret_scrub: DW must be a nonzero multiple of 8");
   end
   if (AW < 1) begin : g_bad_aw
      $error("ecc_rdret_scrub: AW must be at least 1");
   end
   if (CNT_W < 1) begin : g_bad_cnt
      $error("ecc_rdret_scrub: CNT_W must be at least 1");
   end

   logic       ecc_on;
   logic       scrub_on;
   logic       beat_ev;
   beat_kind_e kind;

   assign beat_ev = rd_vld & soft_rst_n;
   assign kind    = classify(rd_stat);

   ecc_cfg_gate u_cfg (
      .clk       (clk),
      .rst_n     (rst_n),
      .soft_rst_n(soft_rst_n),
      .mode      (cfg_ecc_mode),
      .scrub_dis (cfg_scrub_dis),
      .ecc_on    (ecc_on),
      .scrub_on  (scrub_on)
   );

   ecc_rsp_path #(.DW(DW)) u_rsp (
      .clk     (clk),
      .rst_n   (rst_n),
      .beat_ev (beat_ev),
      .ecc_on  (ecc_on),
      .kind    (kind),
      .raw     (rd_raw),
      .fix     (rd_fix),
      .rsp_vld (rsp_vld),
      .rsp_data(rsp_data),
      .rsp_resp(rsp_resp)
   );

   ecc_err_log #(.AW(AW), .CNT_W(CNT_W)) u_log (
      .clk       (clk),
      .rst_n     (rst_n),
      .beat_ev   (beat_ev),
      .ecc_on    (ecc_on),
      .kind      (kind),
      .addr      (rd_addr),
      .log_vld   (log_vld),
      .log_uncorr(log_uncorr),
      .log_addr  (log_addr),
      .cnt_ce    (log_cnt_ce),
      .cnt_ue    (log_cnt_ue)
   );

   ecc_scrub_ctl #(.AW(AW), .DW(DW)) u_scr (
      .clk       (clk),
      .rst_n     (rst_n),
      .soft_rst_n(soft_rst_n),
      .trig      (beat_ev & scrub_on & (kind == BEAT_FIXED)),
      .addr      (rd_addr),
      .fix       (rd_fix),
      .req_rdy   (scr_req_rdy),
      .done      (scr_done),
      .req_vld   (scr_req_vld),
      .req_addr  (scr_addr),
      .req_data  (scr_data),
      .busy      (scr_busy)
   );

   assign mem_wr_vld  = wr_vld;
   assign mem_wr_addr = wr_addr;
   assign mem_wr_data = wr_data;
   assign mem_wr_strb = wr_strb;
endmodule

// File: rtl/ecc_rdret_chk.sv
module ecc_rdret_chk #(
   parameter int AW    = 16,
   parameter int DW    = 32,
   parameter int CNT_W = 8
)(
   input logic             clk,
   input logic             rst_n,
   input logic             soft_rst_n,
   input logic             rd_vld,
   input logic             rsp_vld,
   input logic [1:0]       rsp_resp,
   input logic             log_vld,
   input logic             log_uncorr,
   input logic [CNT_W-1:0] log_cnt_ce,
   input logic             scr_req_vld,
   input logic             scr_req_rdy,
   input logic [AW-1:0]    scr_addr,
   input logic [DW-1:0]    scr_data,
   input logic             scr_busy,
   input logic             scr_done
);
   localparam logic [CNT_W-1:0] CMAX = {CNT_W{1'b1}};

   p_rsp_per_beat_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_vld && soft_rst_n) |=> rsp_vld);

   p_no_extra_rsp_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !(rd_vld && soft_rst_n) |=> !rsp_vld);

   p_slverr_logged_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_vld && rsp_resp == 2'b10) |-> (log_vld && log_uncorr));

   p_log_with_rsp_r2: assert property (@(posedge clk) disable iff (!rst_n)
      log_vld |-> rsp_vld);

   p_no_scrub_ue_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(scr_req_vld) |-> (log_vld && !log_uncorr));

   p_req_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (scr_req_vld && !scr_req_rdy && soft_rst_n)
      |=> (scr_req_vld && $stable(scr_addr) && $stable(scr_data)));

   p_one_scrub_r5: assert property (@(posedge clk) disable iff (!rst_n)
      scr_busy |-> !scr_req_vld);

   p_busy_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (scr_busy && scr_done && soft_rst_n) |=> !scr_busy);

   p_sat_ce_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (log_cnt_ce == CMAX) |=> (log_cnt_ce == CMAX));

   p_soft_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !soft_rst_n |=> (!rsp_vld && !scr_req_vld && !scr_busy));
endmodule

bind ecc_rdret_scrub ecc_rdret_chk #(.AW(AW), .DW(DW), .CNT_W(CNT_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .soft_rst_n (soft_rst_n),
   .rd_vld     (rd_vld),
   .rsp_vld    (rsp_vld),
   .rsp_resp   (rsp_resp),
   .log_vld    (log_vld),
   .log_uncorr (log_uncorr),
   .log_cnt_ce (log_cnt_ce),
   .scr_req_vld(scr_req_vld),
   .scr_req_rdy(scr_req_rdy),
   .scr_addr   (scr_addr),
   .scr_data   (scr_data),
   .scr_busy   (scr_busy),
   .scr_done   (scr_done)
);

// File: tb/tb_ecc_rdret_scrub.sv
`timescale 1ns/1ps
module tb_ecc_rdret_scrub;
   localparam int AW = 16;
   localparam int DW = 32;
   localparam int CW = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          soft_rst_n = 1'b1;
   logic [2:0]    cfg_ecc_mode = 3'b000;
   logic          cfg_scrub_dis = 1'b1;
   logic          rd_vld = 1'b0;
   logic [AW-1:0] rd_addr = '0;
   logic [DW-1:0] rd_raw = '0;
   logic [DW-1:0] rd_fix = '0;
   logic [1:0]    rd_stat = '0;
   logic          rsp_vld;
   logic [DW-1:0] rsp_data;
   logic [1:0]    rsp_resp;
   logic          log_vld;
   logic          log_uncorr;
   logic [AW-1:0] log_addr;
   logic [CW-1:0] log_cnt_ce;
   logic [CW-1:0] log_cnt_ue;
   logic          scr_req_vld;
   logic          scr_req_rdy = 1'b0;
   logic [AW-1:0] scr_addr;
   logic [DW-1:0] scr_data;
   logic          scr_busy;
   logic          scr_done = 1'b0;
   logic          wr_vld = 1'b0;
   logic [AW-1:0] wr_addr = '0;
   logic [DW-1:0] wr_data = '0;
   logic [3:0]    wr_strb = '0;
   logic          mem_wr_vld;
   logic [AW-1:0] mem_wr_addr;
   logic [DW-1:0] mem_wr_data;
   logic [3:0]    mem_wr_strb;

   int n_chk = 0;
   int n_err = 0;
   bit ecc_m = 0;
   int ce_m = 0;
   int ue_m = 0;
   bit finished = 0;

   always #2.5 clk = ~clk;

   ecc_rdret_scrub #(.AW(AW), .DW(DW), .CNT_W(CW)) dut (.*);

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic configure(input logic [2:0] mode, input logic dis);
      @(negedge clk);
      soft_rst_n    = 1'b0;
      cfg_ecc_mode  = mode;
      cfg_scrub_dis = dis;
      @(negedge clk);
      @(negedge clk);
      soft_rst_n = 1'b1;
      ecc_m = (mode == 3'b100);
   endtask

   task automatic beat(input logic [AW-1:0] a, input logic [DW-1:0] raw,
                       input logic [DW-1:0] fix, input logic [1:0] st);
      @(negedge clk);
      rd_vld = 1'b1; rd_addr = a; rd_raw = raw; rd_fix = fix; rd_stat = st;
      @(negedge clk);
      rd_vld = 1'b0;
   endtask

   task automatic rd_check(input logic [AW-1:0] a, input logic [DW-1:0] raw,
                           input logic [DW-1:0] fix, input logic [1:0] st);
      string tag;
      logic [DW-1:0] ed;
      logic [1:0]    er;
      bit            el;
      tag = !ecc_m ? "R8" : (st == 2'b00) ? "R1" : (st == 2'b01) ? "R2" : "R3";
      beat(a, raw, fix, st);
      ed = (ecc_m && st == 2'b01) ? fix : raw;
      er = (ecc_m && st[1]) ? 2'b10 : 2'b00;
      el = ecc_m && (st != 2'b00);
      if (el && st == 2'b01 && ce_m < 255) ce_m++;
      if (el && st[1] && ue_m < 255) ue_m++;
      chk({tag, " rsp_vld"}, rsp_vld, 1'b1);
      chk({tag, " rsp_data"}, rsp_data, ed);
      chk({tag, " rsp_resp"}, rsp_resp, er);
      chk({tag, " log_vld"}, log_vld, el);
      if (el) begin
         chk({tag, " log_uncorr"}, log_uncorr, st[1]);
         chk({tag, " log_addr"}, log_addr, a);
      end
      chk({tag, " cnt_ce"}, log_cnt_ce, ce_m[CW-1:0]);
      chk({tag, " cnt_ue"}, log_cnt_ue, ue_m[CW-1:0]);
   endtask

   task automatic handshake();
      @(negedge clk); scr_req_rdy = 1'b1;
      @(negedge clk); scr_req_rdy = 1'b0;
   endtask

   task automatic finish_scrub();
      @(negedge clk); scr_done = 1'b1;
      @(negedge clk); scr_done = 1'b0;
   endtask

   initial begin
      #(200000 * 5);
      if (!finished) begin
         n_chk++; n_err++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // reset state (R1, R10)
      chk("R1 reset rsp_vld", rsp_vld, 0);
      chk("R1 reset log_vld", log_vld, 0);
      chk("R10 reset scr_req_vld", scr_req_vld, 0);
      chk("R10 reset scr_busy", scr_busy, 0);
      chk("R7 reset cnt_ce", log_cnt_ce, 0);
      chk("R7 reset cnt_ue", log_cnt_ue, 0);

      // sweep of every status over several addresses, scrub off (R1 R2 R3 R6)
      configure(3'b100, 1'b1);
      for (int i = 0; i < 6; i++) begin
         for (int s = 0; s < 4; s++) begin
            rd_check(16'h0100 + 16'(i * 4 + s), 32'hA5000000 + 32'(i * 16 + s),
                     32'h5A000000 + 32'(i * 16 + s), 2'(s));
            chk("R6 no scrub when disabled", scr_req_vld, 0);
            chk("R3 no scrub on uncorrectable", scr_busy, 0);
         end
      end

      // scrub enabled (R4 R5)
      configure(3'b100, 1'b0);
      rd_check(16'h1234, 32'h11110000, 32'h11110001, 2'b01);
      chk("R4 req raised", scr_req_vld, 1);
      chk("R4 req addr", scr_addr, 16'h1234);
      chk("R4 req data", scr_data, 32'h11110001);
      @(negedge clk); @(negedge clk);
      chk("R4 req held", scr_req_vld, 1);
      chk("R4 addr held", scr_addr, 16'h1234);
      rd_check(16'h2222, 32'h22220000, 32'h22220004, 2'b01);
      chk("R5 pending addr unchanged", scr_addr, 16'h1234);
      chk("R5 pending data unchanged", scr_data, 32'h11110001);
      handshake();
      chk("R5 busy after accept", scr_busy, 1);
      chk("R5 req dropped after accept", scr_req_vld, 0);
      rd_check(16'h0055, 32'h33330000, 32'h33330008, 2'b01);
      chk("R5 no second req while busy", scr_req_vld, 0);
      rd_check(16'h0066, 32'h44440000, 32'h44440000, 2'b10);
      chk("R3 no req on uncorrectable", scr_req_vld, 0);
      finish_scrub();
      chk("R5 busy cleared by done", scr_busy, 0);
      rd_check(16'h0077, 32'h55550000, 32'h55550010, 2'b01);
      chk("R4 new req after done", scr_req_vld, 1);
      chk("R4 new req addr", scr_addr, 16'h0077);
      handshake();
      finish_scrub();

      // write pass-through (R11)
      @(negedge clk);
      wr_vld = 1'b1; wr_addr = 16'hBEEF; wr_data = 32'hCAFE0123; wr_strb = 4'b0101;
      #1;
      chk("R11 wr vld", mem_wr_vld, 1);
      chk("R11 wr addr", mem_wr_addr, 16'hBEEF);
      chk("R11 wr data", mem_wr_data, 32'hCAFE0123);
      chk("R11 wr strb", mem_wr_strb, 4'b0101);
      @(negedge clk);
      wr_vld = 1'b0;
      chk("R11 no scrub from write", scr_req_vld, 0);

      // config changes outside soft reset are ignored (R9)
      @(negedge clk);
      cfg_ecc_mode = 3'b000; cfg_scrub_dis = 1'b1;
      rd_check(16'h0088, 32'h66660000, 32'h66660000, 2'b11);
      rd_check(16'h0099, 32'h77770000, 32'h77770020, 2'b01);
      chk("R9 scrub still on", scr_req_vld, 1);
      handshake();
      finish_scrub();

      // soft reset clears scrub, blocks beats (R10)
      rd_check(16'h00AA, 32'h88880000, 32'h88880040, 2'b01);
      chk("R10 pending before soft reset", scr_req_vld, 1);
      @(negedge clk);
      soft_rst_n = 1'b0;
      @(negedge clk);
      chk("R10 req cleared", scr_req_vld, 0);
      chk("R10 busy clear", scr_busy, 0);
      beat(16'h00BB, 32'h99990000, 32'h99990001, 2'b01);
      chk("R10 no rsp in soft reset", rsp_vld, 0);
      chk("R10 no log in soft reset", log_vld, 0);
      @(negedge clk);
      soft_rst_n = 1'b1;
      ecc_m = 1'b0;

      // ECC off (R8)
      for (int s = 0; s < 4; s++) begin
         rd_check(16'h0300 + 16'(s), 32'hD0000000 + 32'(s), 32'hE0000000 + 32'(s), 2'(s));
         chk("R8 no scrub with ECC off", scr_req_vld, 0);
      end

      // saturation (R7)
      configure(3'b100, 1'b1);
      for (int i = 0; i < 260; i++) beat(16'(i), 32'h0, 32'h1, 2'b01);
      chk("R7 ce saturates at 255", log_cnt_ce, 8'd255);
      for (int i = 0; i < 260; i++) beat(16'(i), 32'h0, 32'h0, 2'b10);
      chk("R7 ue saturates at 255", log_cnt_ue, 8'd255);
      configure(3'b100, 1'b1);
      chk("R7 counts kept over soft reset", log_cnt_ce, 8'd255);

      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   end
endmodule